// File: doc/BRIEF.md
# Prescaled Compare Interval Timer

This block is a single-channel interval timer that runs from the system clock. Software sets it up through a small register port that has three 16-bit registers: a control word and two limit values. Once started, the timer divides the clock by a power of two and counts the divided ticks up to the limit that the control word selects. When the count reaches that limit, the timer can raise a one-cycle interrupt request for an external interrupt controller. It then either starts a new period or stops.

A write to the control word is the only way to start or cancel a count. The write clears the count and checks the new setting. The timer starts only if the clock-source field selects the system clock, a limit register is selected and holds a nonzero value, and the stop bit is clear. The timer captures the selected limit when it starts and again each time it reloads. A change to a limit register therefore leaves a period already in progress unchanged.

Top module: `prescaled_interval_timer`

## Requirements
- R1: After reset all three registers read 0, the interrupt output is low and the timer is idle.
- R2: The register port writes the word on `wdata` into the register chosen by `addr` on a clock edge where `wr_en` is high. Address 0 is the control word, 1 is limit A and 2 is limit B. `rdata` shows the addressed register combinationally, and address 3 reads 0.
- R3: Control bits 13:10 hold a prescale exponent e. Values above 8 count as 8. When the control write is sampled on clock edge N, the period is P = 2^e × limit, and the expiry happens on edge N+P.
- R4: Control bits 5:4 choose the limit: 01 uses limit A and 10 uses limit B. With 00 or 11 the timer does not run.
- R5: Control bits 15:14 must be 00 (system clock). With any other value the timer does not run.
- R6: If the selected limit is 0, the timer does not run.
- R7: While control bit 1 (stop) is set, a control write does not start the timer.
- R8: When control bit 2 is set, `irq` is high for the one cycle after each expiry edge. When bit 2 is clear, no expiry raises `irq`.
- R9: When control bit 7 is set, the timer starts a full new period at each expiry. When it is clear, the timer stops after the first expiry.
- R10: A control write cancels any count in progress. Timing then restarts from zero at that write.
- R11: Writing a limit register does not change the period in progress. The new value is used at the next start or repeat reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register |
| irq | output | 1 | Interrupt request pulse |

## Verification
The interrupt is registered, so it is due exactly P edges after the edge that sampled the control write. For repeated periods it is due P edges after the previous pulse. Read data has no latency. The bench drives every write just after a falling edge and counts rising edges from the write edge. It samples `irq` at the falling edge after each rising edge, so a pulse that is one edge early or one edge late shows up as a wrong count. For settings that must not run, the bench watches a window longer than the period the setting would otherwise give and requires `irq` to stay low throughout.

// File: rtl/prescaled_interval_timer.sv
module prescaled_interval_timer #(
  parameter int DW      = 16,
  parameter int EXP_MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int PW = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic [DW-1:0] ctrl_q, lima_q, limb_q, lat_q, cnt_q;
  logic [PW-1:0] pre_q;
  logic          run_q, irq_q;

  logic [3:0]    exp_eff;
  logic [PW:0]   pre_top;
  logic          pre_last, expire, ctrl_wr, start_ok;
  logic [DW-1:0] w_lim, r_lim;

  assign exp_eff  = (ctrl_q[13:10] > 4'(EXP_MAX)) ? 4'(EXP_MAX) : ctrl_q[13:10];
  assign pre_top  = (PW+1)'(1) << exp_eff;
  assign pre_last = ({1'b0, pre_q} == pre_top - 1'b1);
  assign expire   = run_q && pre_last && (cnt_q == lat_q - 1'b1);
  assign ctrl_wr  = wr_en && (addr == 2'd0);

  assign w_lim    = (wdata[5:4] == 2'b01) ? lima_q : limb_q;
  assign start_ok = (wdata[15:14] == 2'b00) && (wdata[5:4] == 2'b01 || wdata[5:4] == 2'b10)
                    && (w_lim != '0) && !wdata[1];
  assign r_lim    = (ctrl_q[5:4] == 2'b01) ? lima_q : limb_q;

  always_comb begin
    case (addr)
      2'd0:    rdata = ctrl_q;
      2'd1:    rdata = lima_q;
      2'd2:    rdata = limb_q;
      default: rdata = '0;
    endcase
  end

  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lima_q <= '0;
      limb_q <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0:    ctrl_q <= wdata;
        2'd1:    lima_q <= wdata;
        2'd2:    limb_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      irq_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
      lat_q <= '0;
    end else if (ctrl_wr) begin
      run_q <= start_ok;
      irq_q <= 1'b0;
      pre_q <= '0;
      cnt_q <= '0;
      lat_q <= w_lim;
    end else begin
      irq_q <= expire && ctrl_q[2];
      if (expire) begin
        pre_q <= '0;
        cnt_q <= '0;
        lat_q <= r_lim;
        run_q <= ctrl_q[7] && (r_lim != '0);
      end else if (run_q) begin
        if (pre_last) begin
          pre_q <= '0;
          cnt_q <= cnt_q + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(run_q) && ctrl_q[2]));

  // R4 R5 R6 R7
  run_config_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (ctrl_q[15:14] == 2'b00 && (ctrl_q[5:4] == 2'b01 || ctrl_q[5:4] == 2'b10)
               && !ctrl_q[1] && lat_q != '0));

  // R9
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_q[7]) |-> !run_q);

  // R10
  ctrl_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (pre_q == '0 && cnt_q == '0));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < lat_q && {1'b0, pre_q} < pre_top));

  // R11
  limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 2'd0 && !expire) |=> $stable(lat_q));
endmodule

// File: tb/test_prescaled_interval_timer.sv
module test_prescaled_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  prescaled_interval_timer i_prescaled_interval_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period(int e, int l);
    int ee = (e > 8) ? 8 : e;
    return (1 << ee) * l;
  endfunction

  function automatic logic [15:0] mk_ctrl(int src, int e, bit rep, int sel, bit ien, bit stop);
    logic [15:0] c = '0;
    c[15:14] = 2'(src);
    c[13:10] = 4'(e);
    c[7]     = rep;
    c[5:4]   = 2'(sel);
    c[2]     = ien;
    c[1]     = stop;
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0;
  endtask

  task automatic wait_irq(int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq) begin k = i; break; end
    end
  endtask

  task automatic quiet(int n, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (irq) ok = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int k;
    bit ok;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      addr = 2'(a); #1;
      chk(rdata == 16'h0, "R1", rdata, 0);
    end
    chk(irq == 1'b0, "R1", irq, 0);

    // R2 register port readback
    wr(2'd1, 16'hA5C3); wr(2'd2, 16'h1234); wr(2'd0, 16'h8002);
    addr = 2'd1; #1; chk(rdata == 16'hA5C3, "R2", rdata, 16'hA5C3);
    addr = 2'd2; #1; chk(rdata == 16'h1234, "R2", rdata, 16'h1234);
    addr = 2'd0; #1; chk(rdata == 16'h8002, "R2", rdata, 16'h8002);
    wr(2'd3, 16'hFFFF);
    addr = 2'd3; #1; chk(rdata == 16'h0, "R2", rdata, 0);
    addr = 2'd0;

    // R3 basic period, exponent 0
    wr(2'd1, 16'd3);
    wr(2'd0, mk_ctrl(0, 0, 0, 1, 1, 0));
    wait_irq(50, k); chk(k == 3, "R3", k, 3);

    // R3 exponent clamp 12 -> 8
    wr(2'd1, 16'd2);
    wr(2'd0, mk_ctrl(0, 12, 0, 1, 1, 0));
    wait_irq(2000, k); chk(k == 512, "R3", k, 512);

    // R4 limit B selection
    wr(2'd2, 16'd5);
    wr(2'd0, mk_ctrl(0, 2, 0, 2, 1, 0));
    wait_irq(100, k); chk(k == 20, "R4", k, 20);

    // R4 select 00 and 11 do not run
    wr(2'd1, 16'd2); wr(2'd2, 16'd2);
    wr(2'd0, mk_ctrl(0, 0, 1, 0, 1, 0));
    quiet(20, ok); chk(ok, "R4", !ok, 0);
    wr(2'd0, mk_ctrl(0, 0, 1, 3, 1, 0));
    quiet(20, ok); chk(ok, "R4", !ok, 0);

    // R5 non-system clock source
    wr(2'd0, mk_ctrl(1, 0, 1, 1, 1, 0));
    quiet(20, ok); chk(ok, "R5", !ok, 0);
    wr(2'd0, mk_ctrl(3, 0, 1, 1, 1, 0));
    quiet(20, ok); chk(ok, "R5", !ok, 0);

    // R6 zero limit
    wr(2'd1, 16'd0);
    wr(2'd0, mk_ctrl(0, 0, 1, 1, 1, 0));
    quiet(40, ok); chk(ok, "R6", !ok, 0);

    // R7 stop bit blocks start
    wr(2'd1, 16'd2);
    wr(2'd0, mk_ctrl(0, 0, 1, 1, 1, 1));
    quiet(20, ok); chk(ok, "R7", !ok, 0);

    // R8 interrupt disabled
    wr(2'd0, mk_ctrl(0, 0, 1, 1, 0, 0));
    quiet(20, ok); chk(ok, "R8", !ok, 0);

    // R9 R8 repeat: equal intervals, single-cycle pulse
    wr(2'd1, 16'd3);
    wr(2'd0, mk_ctrl(0, 1, 1, 1, 1, 0));
    wait_irq(50, k); chk(k == 6, "R9", k, 6);
    wait_irq(50, k); chk(k == 6, "R8", k, 6);
    wait_irq(50, k); chk(k == 6, "R9", k, 6);

    // R9 one-shot stops
    wr(2'd0, mk_ctrl(0, 1, 0, 1, 1, 0));
    wait_irq(50, k); chk(k == 6, "R9", k, 6);
    quiet(30, ok); chk(ok, "R9", !ok, 0);

    // R10 control rewrite restarts
    wr(2'd1, 16'd10);
    wr(2'd0, mk_ctrl(0, 0, 0, 1, 1, 0));
    quiet(6, ok);
    wr(2'd0, mk_ctrl(0, 0, 0, 1, 1, 0));
    wait_irq(50, k); chk(k == 10, "R10", k, 10);

    // R11 limit write mid-period, applied on reload
    wr(2'd1, 16'd4);
    wr(2'd0, mk_ctrl(0, 1, 1, 1, 1, 0));
    wr(2'd1, 16'd10);
    wait_irq(100, k); chk(k == 7, "R11", k, 7);
    wait_irq(100, k); chk(k == 20, "R11", k, 20);

    // R3 R4 random configurations
    for (int t = 0; t < 20; t++) begin
      int e = $urandom_range(0, 11);
      int l = $urandom_range(1, 12);
      int s = $urandom_range(1, 2);
      int p = period(e, l);
      wr(2'(s), 16'(l));
      wr(2'd0, mk_ctrl(0, e, 0, s, 1, 0));
      wait_irq(p + 20, k);
      chk(k == p, "R3", k, p);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule